// File: doc/BRIEF.md
# Four-Level Strided Address Generator

This block walks one multi-dimensional transfer record and emits the sequence of bursts that the record describes. A record has a 64-bit base address, four iteration counts and three signed strides. Level 0 is the innermost loop and counts bytes, so each emitted burst is one run of level-0 bytes. The levels above it step the burst address by their strides, with level 1 iterating fastest. The record type sets how many of the four levels are active.

Each burst leaves on a valid/ready channel as an address and a length. An event pulse marks a chosen loop boundary, and a one-cycle completion flag follows the final accepted burst. Two trigger slots can hold the record back. Each slot names a trigger source and the amount of work that one trigger pulse releases. A pulse that arrives early is kept in a one-deep pending flag.

Top module: `stride_agen`

## Requirements
- R1: After reset `burstValid`, `eventPulse` and `doneFlag` are low. A `start` pulse is taken only while the block is idle, and it captures every configuration input. A `start` seen during a record, or a configuration input changed during a record, has no effect on that record's bursts.
- R2: Burst n carries address base + i1·dim1 + i2·dim2 + i3·dim3, computed modulo 2^64 with each stride sign-extended from 32 bits. Its length equals the level-0 count. Bursts come out with i1 changing fastest, then i2, then i3.
- R3: `recType` 0, 1, 2 and 3 activate one, two, three and four levels. A count above the active levels is taken as one, and a zero count at levels 1 to 3 is also taken as one.
- R4: While `burstValid` is high and `burstReady` is low, `burstValid`, `burstAddr` and `burstLen` hold steady.
- R5: `doneFlag` is high for exactly one cycle, the cycle after the final burst is accepted. The block is then idle and accepts a new `start`.
- R6: With `evtSize` = 0, `eventPulse` fires once, in the cycle after the final burst is accepted.
- R7: With `evtSize` = 1, `eventPulse` fires in the cycle after every accepted burst. With `evtSize` = 2, it fires after each accepted burst that closes a level-1 loop (i1 at its last value). With `evtSize` = 3, it fires after each accepted burst where both i1 and i2 are at their last values.
- R8: If `evtSize` names a level above the active levels (`evtSize` > `recType`), `eventPulse` fires only after the final burst.
- R9: Each slot's select takes one of four codes. Code 0 means the slot does not gate. Code 1 listens to `trigIn[0]` and code 2 listens to `trigIn[1]`, the two global triggers. Code 3 listens to the slot's own local event, which is `trigIn[2]` for slot A and `trigIn[3]` for slot B. Pulses on other inputs do not release the slot.
- R10: Each slot has a kind code that sets how much work one trigger releases. Kind 0 releases one burst. Kind 1 releases one level-2 iteration, which starts where i1 = 0. Kind 2 releases one level-3 iteration, which starts where i1 = i2 = 0. Kind 3 releases the whole record. The first burst of a gated portion is not presented until a trigger arrives.
- R11: A trigger pulse that is not used at once is stored in a one-deep pending flag, and further pulses are lost until that flag is used. Pending flags are cleared when a record starts.
- R12: When both slots gate the same burst, that burst waits until both slots have a trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a record (idle only) |
| baseAddr | input | 64 | Record base address |
| cnt0 | input | 16 | Level-0 count (burst length in bytes) |
| cnt1 | input | 16 | Level-1 iteration count |
| cnt2 | input | 16 | Level-2 iteration count |
| cnt3 | input | 16 | Level-3 iteration count |
| dim1 | input | 32 | Signed level-1 stride |
| dim2 | input | 32 | Signed level-2 stride |
| dim3 | input | 32 | Signed level-3 stride |
| recType | input | 2 | Number of active levels minus one |
| evtSize | input | 2 | Event level code |
| trigSelA | input | 2 | Slot A trigger source |
| trigKindA | input | 2 | Slot A release amount |
| trigSelB | input | 2 | Slot B trigger source |
| trigKindB | input | 2 | Slot B release amount |
| trigIn | input | 4 | Single-cycle trigger pulses |
| burstValid | output | 1 | Burst presented |
| burstReady | input | 1 | Burst accepted by the consumer |
| burstAddr | output | 64 | Burst start address |
| burstLen | output | 16 | Burst length |
| eventPulse | output | 1 | Loop-boundary event |
| doneFlag | output | 1 | Record complete, one cycle |

## Verification
The address walk is tried with a full four-level record using positive strides, and with a record using negative strides whose base sits just below 2^64. The first shows the nesting order and the second shows sign extension and wrap-around. Records of the smaller types carry nonzero counts in their unused levels, and one record has a zero level-1 count, which shows whether those counts are forced to one. Each event code is paired with a record type that either has the named level or lacks it, which separates per-boundary events from the fall-back to the last burst. Gated runs pulse the wrong source, pulse before start, pulse several times while a burst is stalled, and gate one slot per level-2 iteration and the other for the whole record. These runs separate correct source decoding, clearing of the pending flags at start, a one-deep memory and the need for both slots.

// File: rtl/stride_agen_pkg.sv
package stride_agen_pkg;

  // Loops above the innermost one (levels 1..3)
  localparam int NUM_OUTER = 3;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // capture a new record
    logic step;   // a burst was accepted, advance the walk
  } dpCtrl_t;

  // Loop position reported by the datapath; bit 0 is level 1
  typedef struct packed {
    logic [NUM_OUTER-1:0] isLast;
    logic [NUM_OUTER-1:0] isZero;
  } dpStat_t;

  // True when the current burst opens a portion released by one trigger
  function automatic logic chunkStart(input logic [1:0] kind,
                                      input logic [NUM_OUTER-1:0] isZero);
    case (kind)
      2'd0:    chunkStart = 1'b1;
      2'd1:    chunkStart = isZero[0];
      2'd2:    chunkStart = &isZero[1:0];
      default: chunkStart = &isZero;
    endcase
  endfunction

endpackage

// File: rtl/stride_agen_dp.sv
module stride_agen_dp
  import stride_agen_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int CNT_W  = 16,
  parameter int DIM_W  = 32
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  dpCtrl_t                           ctl,
  input  logic [ADDR_W-1:0]                 baseAddr,
  input  logic [CNT_W-1:0]                  innerCnt,
  input  logic [NUM_OUTER-1:0][CNT_W-1:0]   outerCnt,
  input  logic [NUM_OUTER-1:0][DIM_W-1:0]   dimIn,
  input  logic [1:0]                        recType,
  output dpStat_t                           stat,
  output logic [ADDR_W-1:0]                 burstAddr,
  output logic [CNT_W-1:0]                  burstLen
);

  localparam int EXT_W = ADDR_W - DIM_W;

  logic [NUM_OUTER-1:0][CNT_W-1:0]  idx, lim;
  logic [NUM_OUTER-1:0][ADDR_W-1:0] rowAddr, sumAddr, nextRow;
  logic [NUM_OUTER-1:0][DIM_W-1:0]  dimR;
  logic [CNT_W-1:0]                 lenR;
  logic [NUM_OUTER-1:0]             adv, bump, lastV, zeroV;

  // Carry chain: level k advances when every level below it is at its end
  always_comb begin
    adv[0] = 1'b1;
    for (int k = 1; k < NUM_OUTER; k++) adv[k] = adv[k-1] & lastV[k-1];
    bump = adv & ~lastV;
  end

  // A bump at level k reloads every row register at or below k from level k
  always_comb begin
    for (int j = 0; j < NUM_OUTER; j++) begin
      nextRow[j] = '0;
      for (int k = 0; k < NUM_OUTER; k++)
        if (k >= j && bump[k]) nextRow[j] = sumAddr[k];
    end
  end

  for (genvar k = 0; k < NUM_OUTER; k++) begin : g_level
    logic [CNT_W-1:0] effCnt;
    // R3: inactive levels and zero counts run once
    assign effCnt = ((k + 1) > int'(recType) || outerCnt[k] == '0) ?
                    CNT_W'(1) : outerCnt[k];
    // R2: sign-extended stride, wraps modulo 2^ADDR_W
    assign sumAddr[k] = rowAddr[k] + {{EXT_W{dimR[k][DIM_W-1]}}, dimR[k]};
    assign lastV[k]   = (idx[k] == lim[k]);
    assign zeroV[k]   = (idx[k] == '0);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        idx[k]     <= '0;
        lim[k]     <= '0;
        rowAddr[k] <= '0;
        dimR[k]    <= '0;
      end else if (ctl.load) begin
        idx[k]     <= '0;
        lim[k]     <= effCnt - CNT_W'(1);
        rowAddr[k] <= baseAddr;
        dimR[k]    <= dimIn[k];
      end else if (ctl.step) begin
        if (adv[k]) idx[k] <= lastV[k] ? '0 : idx[k] + CNT_W'(1);
        if (|bump[NUM_OUTER-1:k]) rowAddr[k] <= nextRow[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)         lenR <= '0;
    else if (ctl.load) lenR <= innerCnt;
  end

  assign stat.isLast = lastV;
  assign stat.isZero = zeroV;
  assign burstAddr   = rowAddr[0];
  assign burstLen    = lenR;

endmodule

// File: rtl/stride_agen_ctrl.sv
module stride_agen_ctrl
  import stride_agen_pkg::*;
#(
  parameter int NUM_SLOTS = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       start,
  input  logic [1:0]                 recType,
  input  logic [1:0]                 evtSize,
  input  logic [NUM_SLOTS-1:0][1:0]  slotSel,
  input  logic [NUM_SLOTS-1:0][1:0]  slotKind,
  input  logic [NUM_SLOTS+1:0]       trigIn,
  input  dpStat_t                    stat,
  input  logic                       burstReady,
  output dpCtrl_t                    ctl,
  output logic                       burstValid,
  output logic                       eventPulse,
  output logic                       doneFlag
);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} state_t;

  state_t                      state;
  logic [1:0]                  typR, evtR;
  logic [NUM_SLOTS-1:0][1:0]   selR, kindR;
  logic [NUM_SLOTS-1:0]        pend, hit, need;
  logic                        granted, gateOk, grantNow, hs, finalB, evtHit, load;

  // R9: source decode per slot
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_comb begin
      case (selR[s])
        2'd1:    hit[s] = trigIn[0];
        2'd2:    hit[s] = trigIn[1];
        2'd3:    hit[s] = trigIn[2 + s];
        default: hit[s] = 1'b0;
      endcase
      need[s] = (selR[s] != 2'd0) && chunkStart(kindR[s], stat.isZero);
    end

    // R11: one-deep pending, cleared on start and when used
    always_ff @(posedge clk) begin
      if (!rstN || load)            pend[s] <= 1'b0;
      else if (grantNow && need[s]) pend[s] <= 1'b0;
      else                          pend[s] <= pend[s] | hit[s];
    end
  end

  assign load       = (state == S_IDLE) && start;
  assign gateOk     = &(~need | pend | hit);          // R12
  assign grantNow   = (state == S_RUN) && !granted && gateOk;
  assign burstValid = (state == S_RUN) && (granted || gateOk);
  assign hs         = burstValid && burstReady;
  assign finalB     = &stat.isLast;
  assign ctl.load   = load;
  assign ctl.step   = hs;
  assign doneFlag   = (state == S_FIN);

  // R6 R7 R8: event level selection
  always_comb begin
    if (evtR == 2'd0 || evtR > typR) evtHit = finalB;
    else if (evtR == 2'd1)           evtHit = 1'b1;
    else if (evtR == 2'd2)           evtHit = stat.isLast[0];
    else                             evtHit = &stat.isLast[1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_IDLE;
      granted    <= 1'b0;
      eventPulse <= 1'b0;
      typR       <= '0;
      evtR       <= '0;
      selR       <= '0;
      kindR      <= '0;
    end else begin
      eventPulse <= hs && evtHit;
      granted    <= load ? 1'b0 : ((granted | grantNow) & ~hs);
      case (state)
        S_IDLE: if (start) begin
          state <= S_RUN;
          typR  <= recType;
          evtR  <= evtSize;
          selR  <= slotSel;
          kindR <= slotKind;
        end
        S_RUN:   if (hs && finalB) state <= S_FIN;
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/stride_agen.sv
module stride_agen
  import stride_agen_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int CNT_W  = 16,
  parameter int DIM_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [CNT_W-1:0]  cnt0,
  input  logic [CNT_W-1:0]  cnt1,
  input  logic [CNT_W-1:0]  cnt2,
  input  logic [CNT_W-1:0]  cnt3,
  input  logic [DIM_W-1:0]  dim1,
  input  logic [DIM_W-1:0]  dim2,
  input  logic [DIM_W-1:0]  dim3,
  input  logic [1:0]        recType,
  input  logic [1:0]        evtSize,
  input  logic [1:0]        trigSelA,
  input  logic [1:0]        trigKindA,
  input  logic [1:0]        trigSelB,
  input  logic [1:0]        trigKindB,
  input  logic [3:0]        trigIn,
  output logic              burstValid,
  input  logic              burstReady,
  output logic [ADDR_W-1:0] burstAddr,
  output logic [CNT_W-1:0]  burstLen,
  output logic              eventPulse,
  output logic              doneFlag
);

  dpCtrl_t ctl;
  dpStat_t stat;

  stride_agen_ctrl #(.NUM_SLOTS(2)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .recType    (recType),
    .evtSize    (evtSize),
    .slotSel    ({trigSelB, trigSelA}),
    .slotKind   ({trigKindB, trigKindA}),
    .trigIn     (trigIn),
    .stat       (stat),
    .burstReady (burstReady),
    .ctl        (ctl),
    .burstValid (burstValid),
    .eventPulse (eventPulse),
    .doneFlag   (doneFlag)
  );

  stride_agen_dp #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DIM_W(DIM_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .baseAddr  (baseAddr),
    .innerCnt  (cnt0),
    .outerCnt  ({cnt3, cnt2, cnt1}),
    .dimIn     ({dim3, dim2, dim1}),
    .recType   (recType),
    .stat      (stat),
    .burstAddr (burstAddr),
    .burstLen  (burstLen)
  );

endmodule

// File: rtl/stride_agen_chk.sv
module stride_agen_chk #(
  parameter int ADDR_W = 64,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              burstValid,
  input logic              burstReady,
  input logic [ADDR_W-1:0] burstAddr,
  input logic [CNT_W-1:0]  burstLen,
  input logic              eventPulse,
  input logic              doneFlag
);

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    burstValid && !burstReady |=> burstValid && $stable(burstAddr) && $stable(burstLen)); // R4

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag |=> !doneFlag); // R5

  AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag |-> $past(burstValid && burstReady)); // R5

  AST_DONE_NO_BURST: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag |-> !burstValid); // R5

  AST_EVENT_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    eventPulse |-> $past(burstValid && burstReady)); // R7

endmodule

bind stride_agen stride_agen_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .burstValid (burstValid),
  .burstReady (burstReady),
  .burstAddr  (burstAddr),
  .burstLen   (burstLen),
  .eventPulse (eventPulse),
  .doneFlag   (doneFlag)
);

// File: tb/stride_agen_tb.sv
module stride_agen_tb;

  logic        clk = 1'b0;
  logic        rstN, start, burstReady, burstValid, eventPulse, doneFlag;
  logic [63:0] baseAddr, burstAddr;
  logic [15:0] cnt0, cnt1, cnt2, cnt3, burstLen;
  logic [31:0] dim1, dim2, dim3;
  logic [1:0]  recType, evtSize, trigSelA, trigKindA, trigSelB, trigKindB;
  logic [3:0]  trigIn;

  // configuration the bench expects the current record to use
  logic [63:0] cBase;
  logic [15:0] cC0, cC1, cC2, cC3;
  logic [31:0] cD1, cD2, cD3;
  logic [1:0]  cType, cEvt;

  int vectors = 0, miscompares = 0, readyMode = 0, cyc = 0;
  int hsCnt, lastHsCyc, doneCnt, strayEv, doneBad;
  logic [63:0] gotAddr [64];
  logic [15:0] gotLen  [64];
  logic [63:0] evMask;

  always #5 clk = ~clk;

  stride_agen u_dut (
    .clk(clk), .rstN(rstN), .start(start), .baseAddr(baseAddr),
    .cnt0(cnt0), .cnt1(cnt1), .cnt2(cnt2), .cnt3(cnt3),
    .dim1(dim1), .dim2(dim2), .dim3(dim3),
    .recType(recType), .evtSize(evtSize),
    .trigSelA(trigSelA), .trigKindA(trigKindA),
    .trigSelB(trigSelB), .trigKindB(trigKindB),
    .trigIn(trigIn), .burstValid(burstValid), .burstReady(burstReady),
    .burstAddr(burstAddr), .burstLen(burstLen),
    .eventPulse(eventPulse), .doneFlag(doneFlag)
  );

  // Monitor: samples on the falling edge
  always @(negedge clk) begin
    cyc++;
    if (eventPulse) begin
      if (lastHsCyc == cyc - 1 && hsCnt > 0 && hsCnt <= 64) evMask[hsCnt-1] = 1'b1;
      else strayEv++;
    end
    if (doneFlag) begin
      doneCnt++;
      if (lastHsCyc != cyc - 1) doneBad++;
    end
    if (burstValid && burstReady) begin
      if (hsCnt < 64) begin
        gotAddr[hsCnt] = burstAddr;
        gotLen[hsCnt]  = burstLen;
      end
      hsCnt++;
      lastHsCyc = cyc;
    end
  end

  initial begin
    burstReady = 1'b0;
    forever begin
      @(posedge clk); #1;
      case (readyMode)
        0:       burstReady = 1'b1;
        1:       burstReady = (cyc % 3) != 0;
        default: burstReady = 1'b0;
      endcase
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic waitCyc(input int n); repeat (n) tick(); endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clearMon();
    hsCnt = 0; lastHsCyc = -10; doneCnt = 0; strayEv = 0; doneBad = 0; evMask = '0;
  endtask

  task automatic setCfg(input logic [63:0] b, input logic [15:0] c0, c1, c2, c3,
                        input logic [31:0] d1, d2, d3, input logic [1:0] ty, ev);
    cBase = b; cC0 = c0; cC1 = c1; cC2 = c2; cC3 = c3;
    cD1 = d1; cD2 = d2; cD3 = d3; cType = ty; cEvt = ev;
    baseAddr = b; cnt0 = c0; cnt1 = c1; cnt2 = c2; cnt3 = c3;
    dim1 = d1; dim2 = d2; dim3 = d3; recType = ty; evtSize = ev;
  endtask

  task automatic setTrig(input logic [1:0] sa, ka, sb, kb);
    trigSelA = sa; trigKindA = ka; trigSelB = sb; trigKindB = kb;
  endtask

  task automatic pulseStart(); start = 1'b1; tick(); start = 1'b0; endtask
  task automatic pulseTrig(input int b); trigIn[b] = 1'b1; tick(); trigIn = '0; endtask

  task automatic waitDone(input int limit);
    for (int t = 0; t < limit && doneCnt == 0; t++) tick();
    waitCyc(3);
  endtask

  function automatic int effN(input logic [15:0] c, input int lvl, input logic [1:0] ty);
    return (lvl > int'(ty) || c == 16'd0) ? 1 : int'(c);
  endfunction

  // Compare the captured record with the bench model
  task automatic checkRecord(input string tagA, input string tagE);
    int n1, n2, n3, k;
    logic [63:0] ex, exMask;
    bit evb;
    n1 = effN(cC1, 1, cType); n2 = effN(cC2, 2, cType); n3 = effN(cC3, 3, cType);
    k = 0; exMask = '0;
    for (int i3 = 0; i3 < n3; i3++)
      for (int i2 = 0; i2 < n2; i2++)
        for (int i1 = 0; i1 < n1; i1++) begin
          ex = cBase + 64'(i1) * 64'($signed(cD1)) + 64'(i2) * 64'($signed(cD2))
                     + 64'(i3) * 64'($signed(cD3));
          if (k < 64) begin
            chk(gotAddr[k] === ex, tagA, gotAddr[k], ex);
            chk(gotLen[k] === cC0, "R2 length", 64'(gotLen[k]), 64'(cC0));
          end
          if (cEvt == 2'd0 || cEvt > cType)
            evb = (i1 == n1 - 1) && (i2 == n2 - 1) && (i3 == n3 - 1);
          else if (cEvt == 2'd1) evb = 1'b1;
          else if (cEvt == 2'd2) evb = (i1 == n1 - 1);
          else                   evb = (i1 == n1 - 1) && (i2 == n2 - 1);
          if (k < 64) exMask[k] = evb;
          k++;
        end
    chk(hsCnt == k, "R3 burst count", 64'(hsCnt), 64'(k));
    chk(evMask === exMask && strayEv == 0, tagE, evMask, exMask);
    chk(doneCnt == 1 && doneBad == 0, "R5 done once after final accept", 64'(doneCnt), 64'd1);
  endtask

  task automatic runRecord(input string tagA, input string tagE);
    clearMon();
    pulseStart();
    waitDone(3000);
    checkRecord(tagA, tagE);
  endtask

  task automatic tReset();
    chk(!burstValid && !eventPulse && !doneFlag, "R1 reset outputs",
        64'({burstValid, eventPulse, doneFlag}), 64'd0);
  endtask

  task automatic tFourLevel();
    readyMode = 0; setTrig(0, 0, 0, 0);
    setCfg(64'h1000, 16'd16, 16'd3, 16'd2, 16'd2, 32'h40, 32'h400, 32'h10000, 2'd3, 2'd1);
    runRecord("R2 address walk", "R7 event every burst");
  endtask

  task automatic tNegWrap();
    readyMode = 1; setTrig(0, 0, 0, 0);
    setCfg(64'hFFFF_FFFF_FFFF_FF00, 16'd4, 16'd2, 16'd3, 16'd2,
           32'hFFFF_FFF8, 32'h100, 32'hFFFF_F000, 2'd3, 2'd2);
    runRecord("R2 R4 negative stride wrap under back-pressure", "R7 event per level-1 wrap");
  endtask

  task automatic tLevel3Evt();
    readyMode = 0; setTrig(0, 0, 0, 0);
    setCfg(64'h8000, 16'd8, 16'd2, 16'd3, 16'd2, 32'h10, 32'h100, 32'h1000, 2'd3, 2'd3);
    runRecord("R2 address walk", "R7 event per level-2 wrap");
  endtask

  task automatic tUnusedLevels();
    readyMode = 0; setTrig(0, 0, 0, 0);
    setCfg(64'h2000, 16'd32, 16'd4, 16'd5, 16'd7, 32'h20, 32'h200, 32'h2000, 2'd1, 2'd3);
    runRecord("R3 unused levels as one", "R8 event only at end");
  endtask

  task automatic tZeroCount();
    readyMode = 0; setTrig(0, 0, 0, 0);
    setCfg(64'h3000, 16'd8, 16'd0, 16'd3, 16'd9, 32'h8, 32'h80, 32'h800, 2'd2, 2'd0);
    runRecord("R3 zero count as one", "R6 event at completion");
  endtask

  task automatic tOneDim();
    readyMode = 0; setTrig(0, 0, 0, 0);
    setCfg(64'h4000, 16'd100, 16'd5, 16'd5, 16'd5, 32'h8, 32'h80, 32'h800, 2'd0, 2'd1);
    runRecord("R3 single burst", "R8 type 0 code 1 at end");
  endtask

  task automatic tIgnoredStart();
    readyMode = 2; setTrig(0, 0, 0, 0);
    setCfg(64'h5000, 16'd4, 16'd2, 16'd2, 16'd1, 32'h10, 32'h100, 32'h1000, 2'd3, 2'd1);
    clearMon();
    pulseStart();
    waitCyc(4);
    baseAddr = 64'hDEAD_0000; cnt1 = 16'd9;
    pulseStart();
    readyMode = 0;
    waitDone(3000);
    checkRecord("R1 start and inputs ignored while busy", "R7 event every burst");
  endtask

  task automatic tGatedSingle();
    readyMode = 0; setTrig(2'd1, 2'd0, 2'd0, 2'd0);
    setCfg(64'h6000, 16'd8, 16'd3, 16'd1, 16'd1, 32'h40, 32'h0, 32'h0, 2'd1, 2'd0);
    clearMon();
    pulseTrig(0);               // before start: must be forgotten
    waitCyc(2);
    readyMode = 2;
    pulseStart();
    waitCyc(8);
    chk(hsCnt == 0 && !burstValid, "R11 pending cleared at start", 64'(hsCnt), 64'd0);
    pulseTrig(0);
    waitCyc(3);
    chk(burstValid === 1'b1, "R10 trigger releases one burst", 64'(burstValid), 64'd1);
    pulseTrig(0);               // remembered
    pulseTrig(0);               // lost
    readyMode = 0;
    waitCyc(6);
    chk(hsCnt == 2, "R11 one-deep pending", 64'(hsCnt), 64'd2);
    pulseTrig(1);               // wrong global source
    waitCyc(5);
    chk(hsCnt == 2, "R9 other source ignored", 64'(hsCnt), 64'd2);
    pulseTrig(0);
    waitDone(100);
    checkRecord("R10 gated addresses", "R6 event at completion");
  endtask

  task automatic tGatedTwoSlots();
    readyMode = 0; setTrig(2'd3, 2'd1, 2'd2, 2'd3);
    setCfg(64'h7000, 16'd4, 16'd2, 16'd2, 16'd1, 32'h10, 32'h100, 32'h0, 2'd3, 2'd0);
    clearMon();
    pulseStart();
    pulseTrig(2);               // slot A local event
    waitCyc(6);
    chk(hsCnt == 0, "R12 both slots required", 64'(hsCnt), 64'd0);
    pulseTrig(1);               // slot B global 1
    waitCyc(6);
    chk(hsCnt == 2, "R10 level-2 iteration per trigger", 64'(hsCnt), 64'd2);
    pulseTrig(3);               // slot B local, not slot A source
    waitCyc(5);
    chk(hsCnt == 2, "R9 local event per slot", 64'(hsCnt), 64'd2);
    pulseTrig(2);
    waitDone(100);
    checkRecord("R10 gated addresses", "R6 event at completion");
  endtask

  initial begin
    rstN = 1'b0; start = 1'b0; trigIn = '0;
    setTrig(0, 0, 0, 0);
    setCfg('0, '0, '0, '0, '0, '0, '0, '0, '0, '0);
    waitCyc(4);
    tReset();
    rstN = 1'b1;
    waitCyc(2);
    tReset();
    tFourLevel();
    tNegWrap();
    tLevel3Evt();
    tUnusedLevels();
    tZeroCount();
    tOneDim();
    tIgnoredStart();
    tGatedSingle();
    tGatedTwoSlots();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule